// File: doc/BRIEF.md
# Dual-Strobe Cascadable Up/Down Counter

This block is a small reversible binary counter, four bits wide by default, with no direction pin. Two strobes set the direction instead. One strobe counts up and the other counts down. The count steps once on the rising edge of whichever strobe is pulsed while the other strobe rests high. Both strobes are sampled in the system clock domain, so the strobes themselves are never used as clocks. All count bits are held in one register and change together on a single clock edge.

Two controls override counting. A synchronous active-high clear forces the count to zero. An active-low load copies a preset word into the count. While either control is active, strobe edges are discarded. The active-low carry and borrow outputs are decoded combinationally from the count and from the live level of the matching strobe. Each one falls only while its strobe is low at the terminal count, so its rising edge arrives as the strobe returns high. Stages can therefore be chained with no glue logic: carry feeds the next stage's up strobe and borrow feeds its down strobe.

Top module: `updn_strobe_counter`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, the count is 0. With both strobes high, `carry_n` and `borrow_n` are both 1. All count bits change on the same clock edge.
- R2: A rising edge on `up_stb` (previous sample 0, new sample 1) while the sampled `dn_stb` is 1 increments the count. The new value is visible after the second rising clock edge at which `up_stb` is seen high. The count wraps from 15 to 0.
- R3: A rising edge on `dn_stb` while the sampled `up_stb` is 1 decrements the count, with the same latency as R2. The count wraps from 0 to 15.
- R4: When `load_n` is 0 and `clear` is 0, the count takes the value of `preset` at the next clock edge. Strobe edges seen while `load_n` is 0 are ignored.
- R5: When `clear` is 1, the count becomes 0 at the next clock edge. This overrides `load_n` and both strobes.
- R6: A strobe edge does not change the count if the other strobe is sampled low, or if both strobes rise in the same sample.
- R7: `borrow_n` is 0 exactly when the count is 0 and `dn_stb` is low. Otherwise it is 1. It follows `dn_stb` in the same cycle.
- R8: `carry_n` is 0 exactly when the count is 15 and `up_stb` is low. Otherwise it is 1. It follows `up_stb` in the same cycle.
- R9: Two stages chained as carry-to-up and borrow-to-down behave as one 8-bit counter under up and down pulses applied to the low stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low parallel preset enable |
| preset | input | W | Preset data word |
| up_stb | input | 1 | Count-up strobe, idles high |
| dn_stb | input | 1 | Count-down strobe, idles high |
| count | output | W | Current count |
| carry_n | output | 1 | Active-low carry, gated by `up_stb` |
| borrow_n | output | 1 | Active-low borrow, gated by `dn_stb` |

## Verification
A strobe pulse can fall in the same cycles as a load or a clear. The bench provokes this by holding `load_n` low, or `clear` high, through a whole up pulse and across every preset value. After the control is released, the count must equal the preset or zero, and it must not be one step past that value. A second collision is two strobes rising in one sample. It is judged by checking that the count holds still. A lone rising edge against a low partner strobe is judged the same way, and is followed by a check that the partner's later rising edge still counts.

// File: rtl/updn_strobe_counter.sv
module updn_strobe_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         up_stb,
  input  logic         dn_stb,
  output logic [W-1:0] count,
  output logic         carry_n,
  output logic         borrow_n
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic up_q, up_prev, dn_q, dn_prev;
  logic up_rise, dn_rise, step_up, step_dn, hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q    <= 1'b1;
      up_prev <= 1'b1;
      dn_q    <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_q    <= up_stb;
      up_prev <= up_q;
      dn_q    <= dn_stb;
      dn_prev <= dn_q;
    end
  end

  assign up_rise = up_q & ~up_prev;
  assign dn_rise = dn_q & ~dn_prev;
  assign hold    = clear | ~load_n;
  assign step_up = ~hold & up_rise & dn_q & ~dn_rise;
  assign step_dn = ~hold & dn_rise & up_q & ~up_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (!load_n) count <= preset;
    else if (step_up) count <= count + ONE;
    else if (step_dn) count <= count - ONE;
  end

  assign carry_n  = ~((count == TOP) & ~up_stb);
  assign borrow_n = ~((count == '0) & ~dn_stb);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  assert_load_takes_preset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load_n) |=> count == $past(preset));

  assert_single_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n) |=> (count == $past(count) || count == $past(count) + ONE
                            || count == $past(count) - ONE));

  assert_up_needs_down_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && !dn_q) |=> count != $past(count) + ONE);

  assert_down_needs_up_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && !up_q) |=> count != $past(count) - ONE);

  assert_twin_edge_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && load_n && up_rise && dn_rise) |=> $stable(count));

  always_comb begin
    if (rst_n) begin
      assert_borrow_gated_R7: assert (borrow_n || !dn_stb);
      assert_carry_gated_R8:  assert (carry_n || !up_stb);
    end
  end
endmodule

// File: tb/updn_strobe_counter_tb.sv
`timescale 1ns/1ps
module updn_strobe_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, ld_n = 1'b1, up = 1'b1, dn = 1'b1;
  logic [3:0] pre = '0;
  logic [3:0] lo_q, hi_q;
  logic lo_c, lo_b, hi_c, hi_b;
  int checks = 0, fails = 0, cycles = 0;
  int exp_lo = 0, exp_hi = 0;
  bit done = 0;

  always #2 clk = ~clk;

  updn_strobe_counter #(.W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clr), .load_n(ld_n), .preset(pre),
    .up_stb(up), .dn_stb(dn), .count(lo_q), .carry_n(lo_c), .borrow_n(lo_b));

  updn_strobe_counter #(.W(4)) u_next (
    .clk(clk), .rst_n(rst_n), .clear(1'b0), .load_n(1'b1), .preset(4'd0),
    .up_stb(lo_c), .dn_stb(lo_b), .count(hi_q), .carry_n(hi_c), .borrow_n(hi_b));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string tag);
    chk({tag, " count"}, int'(lo_q), exp_lo);
    chk({tag, " R9 upper stage"}, int'(hi_q), exp_hi);
  endtask

  task automatic up_pulse(bit counts);
    bit wrap;
    up = 1'b0; #0.5;
    chk("R8 carry while up low", int'(lo_c), (exp_lo == 15) ? 0 : 1);
    tick(2);
    wrap = (exp_lo == 15);
    up = 1'b1; #0.5;
    chk("R8 carry after up high", int'(lo_c), 1);
    tick(3);
    if (wrap) exp_hi = (exp_hi + 1) % 16;
    if (counts) exp_lo = (exp_lo + 1) % 16;
  endtask

  task automatic dn_pulse(bit counts);
    bit wrap;
    dn = 1'b0; #0.5;
    chk("R7 borrow while dn low", int'(lo_b), (exp_lo == 0) ? 0 : 1);
    tick(2);
    wrap = (exp_lo == 0);
    dn = 1'b1; #0.5;
    chk("R7 borrow after dn high", int'(lo_b), 1);
    tick(3);
    if (wrap) exp_hi = (exp_hi + 15) % 16;
    if (counts) exp_lo = (exp_lo + 15) % 16;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset count", int'(lo_q), 0);
    chk("R1 reset carry", int'(lo_c), 1);
    chk("R1 reset borrow", int'(lo_b), 1);

    for (int i = 0; i < 40; i++) begin
      up_pulse(1'b1);
      check_state("R2 up sweep");
    end
    for (int i = 0; i < 50; i++) begin
      dn_pulse(1'b1);
      check_state("R3 down sweep");
    end

    for (int d = 0; d < 16; d++) begin
      ld_n = 1'b0; pre = 4'(d);
      tick(1);
      exp_lo = d;
      up_pulse(1'b0);
      ld_n = 1'b1;
      tick(2);
      check_state("R4 load with up pulse");
    end

    ld_n = 1'b0; pre = 4'd9; clr = 1'b1;
    tick(1);
    exp_lo = 0;
    up_pulse(1'b0);
    clr = 1'b0; ld_n = 1'b1;
    tick(2);
    check_state("R5 clear over load and strobe");

    ld_n = 1'b0; pre = 4'd5; tick(1); ld_n = 1'b1; tick(2);
    exp_lo = 5;
    check_state("R4 load five");

    up = 1'b0; dn = 1'b0; tick(2);
    up = 1'b1; dn = 1'b1; tick(3);
    check_state("R6 twin rising edges");

    dn = 1'b0; tick(2);
    up_pulse(1'b0);
    check_state("R6 up edge with dn low");
    dn = 1'b1; tick(3);
    exp_lo = 4;
    check_state("R3 dn release counts");

    up = 1'b0; tick(2);
    dn_pulse(1'b0);
    check_state("R6 dn edge with up low");
    up = 1'b1; tick(3);
    exp_lo = 5;
    check_state("R2 up release counts");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule